// File: doc/BRIEF.md
# 16-bit ALU with Status Flags

This block is the execute-stage datapath of a small two-address processor. It takes a source operand and a destination operand. The source is either a register value or an immediate that decode has already sign-extended. The destination is the value of the register that the result overwrites. Combinational logic produces a result and a write-back strobe in the same cycle. A five-bit status register sits beside the datapath and changes at the clock edge on which an instruction executes, and only in the bits that the executing operation is allowed to touch.

The arithmetic unit runs add, subtract and compare on one shared adder. Add and subtract report carry and signed overflow. Compare performs the same subtraction, writes nothing back, and reports equality, unsigned less-than and signed less-than. The logical, move, upper-immediate and single-step shift operations never disturb the status bits.

Register file, instruction decode and memory access belong to neighbouring blocks.

Top module: `alu16_flags`

## Requirements
- R1: Operation code 0 (add) drives result_o with dst_i + src_i, taken modulo 2^16.
- R2: Operation code 1 (subtract) drives result_o with dst_i - src_i, taken modulo 2^16.
- R3: An executed add or subtract loads carry (flags_o bit 0) and overflow (flags_o bit 1) and leaves bits 4:2 unchanged. Carry is the carry-out of the 17-bit sum, and for subtract that sum is dst_i + ~src_i + 1, so carry is 1 exactly when dst_i >= src_i unsigned. Overflow is set when the signed result does not fit in 16 bits.
- R4: Operation code 2 (compare) loads zero (bit 3) = (dst_i == src_i), below (bit 2) = dst_i < src_i unsigned, and negative (bit 4) = dst_i < src_i signed. Bits 1:0 stay unchanged and wb_o stays 0.
- R5: Operation codes 3, 4 and 5 drive result_o with dst_i AND, OR and XOR src_i respectively.
- R6: Operation code 6 (move) drives result_o with src_i.
- R7: Operation code 7 (load upper) drives result_o with src_i[7:0] in bits 15:8 and zeros in bits 7:0.
- R8: Operation code 8 (shift) moves dst_i by one place. It shifts left when src_i[15] is 0 and right when src_i[15] is 1, and the vacated bit is always filled with 0.
- R9: Operation codes 3 to 8 leave all five flag bits unchanged.
- R10: Flags change only at a rising clock edge where exec_i is 1, and the new value appears on flags_o after that edge. With exec_i at 0, wb_o is 0 and the flags hold.
- R11: A rising edge with rst_n low clears all flag bits to 0.
- R12: Operation codes 9 to 15 drive result_o with dst_i, hold wb_o at 0 and leave the flags unchanged.
- R13: wb_o equals exec_i for operation codes 0, 1 and 3 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| exec_i | input | 1 | An instruction executes in this cycle |
| op_i | input | 4 | Operation code |
| src_i | input | 16 | Source operand: register value or sign-extended immediate |
| dst_i | input | 16 | Destination register value, the first operand |
| result_o | output | 16 | Value to write back to the destination |
| wb_o | output | 1 | Write result_o back to the destination |
| flags_o | output | 5 | Status bits: 0 carry, 1 overflow, 2 below, 3 zero, 4 negative |

## Verification
The assertions assume that op_i, src_i and dst_i hold a defined value at every rising edge after reset, and that exec_i is never unknown. Every check of the flag scope compares a flag bit with its value one edge earlier. The bench meets these assumptions by driving all inputs on the falling edge from tasks that always assign every input, including the cycles with exec_i low. It also holds rst_n low from time zero, so the flag register has a known value before any assertion is enabled.

// File: rtl/alu16_pkg.sv
// Shared definitions for the 16-bit ALU: operation codes and the status-flag layout.
// Assumes operation codes 9..15 are treated as no-operations by every unit.
package alu16_pkg;

    localparam int DATA_W = 16;
    localparam int OP_W   = 4;
    localparam int FLAG_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_MOV = 4'd6,
        OP_LUI = 4'd7,
        OP_SHF = 4'd8
    } alu_op_e;

    // Bit 0 is carry, rising to bit 4 negative.
    typedef struct packed {
        logic neg;
        logic zero;
        logic below;
        logic ovf;
        logic carry;
    } flags_t;

endpackage

// File: rtl/alu16_arith.sv
// Shared adder for add, subtract and compare. Computes result and every candidate flag.
// Assumes sub_i selects dst - src (subtract or compare); otherwise dst + src.
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         sub_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    output logic [W-1:0] res_o,
    output flags_t       cand_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] opnd_b;
    logic [W:0]   sum;

    // Form the second adder operand and the (W+1)-bit sum with carry-in for subtract.
    always_comb begin
        opnd_b = sub_i ? ~src_i : src_i;
        sum    = {1'b0, dst_i} + {1'b0, opnd_b} + {{W{1'b0}}, sub_i};
        res_o  = sum[W-1:0];
    end

    // Derive both unsigned and signed views of the outcome.
    always_comb begin
        cand_o.carry = sum[W];
        cand_o.ovf   = (dst_i[MSB] == opnd_b[MSB]) && (res_o[MSB] != dst_i[MSB]);
        cand_o.zero  = (res_o == '0);
        cand_o.below = ~sum[W];
        cand_o.neg   = res_o[MSB] ^ cand_o.ovf;
    end

endmodule

// File: rtl/alu16_logic.sv
// Non-arithmetic results: bitwise ops, move, load-upper and the one-place shift.
// Assumes the caller only uses this result for operation codes other than 0..2.
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    output logic [W-1:0] res_o
);
    localparam int HALF = W / 2;
    localparam int MSB  = W - 1;

    // Select the result of the requested non-arithmetic operation.
    always_comb begin
        case (op_i)
            OP_AND:  res_o = dst_i & src_i;
            OP_OR:   res_o = dst_i | src_i;
            OP_XOR:  res_o = dst_i ^ src_i;
            OP_MOV:  res_o = src_i;
            OP_LUI:  res_o = {src_i[HALF-1:0], {(W-HALF){1'b0}}};
            OP_SHF:  res_o = src_i[MSB] ? {1'b0, dst_i[MSB:1]} : {dst_i[MSB-1:0], 1'b0};
            default: res_o = dst_i;
        endcase
    end

endmodule

// File: rtl/alu16_flagreg.sv
// Status register that loads only the bits an operation class owns.
// Assumes upd_arith_i and upd_cmp_i are never both high.
module alu16_flagreg
    import alu16_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   upd_arith_i,
    input  logic   upd_cmp_i,
    input  flags_t cand_i,
    output flags_t flags_o
);
    flags_t flags_q;

    // Merge owned bits from the candidate into the held flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            if (upd_arith_i) begin
                flags_q.carry <= cand_i.carry;
                flags_q.ovf   <= cand_i.ovf;
            end
            if (upd_cmp_i) begin
                flags_q.zero  <= cand_i.zero;
                flags_q.below <= cand_i.below;
                flags_q.neg   <= cand_i.neg;
            end
        end
    end

    assign flags_o = flags_q;

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_arith_i || upd_cmp_i) |=> $stable(flags_q));

    assert_arith_scope_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_arith_i |=> $stable({flags_q.neg, flags_q.zero, flags_q.below}));

    assert_cmp_scope_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_cmp_i |=> $stable({flags_q.ovf, flags_q.carry}));

endmodule

// File: rtl/alu16_flags.sv
// Top of the ALU: routes operands to the arithmetic and logic units, selects the
// result, raises write-back and gates flag updates by operation class.
// Assumes src_i already carries any sign extension of an immediate.
module alu16_flags
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [W-1:0]      src_i,
    input  logic [W-1:0]      dst_i,
    output logic [W-1:0]      result_o,
    output logic              wb_o,
    output logic [FLAG_W-1:0] flags_o
);
    alu_op_e      op;
    logic         is_arith;
    logic         is_cmp;
    logic         is_known;
    logic [W-1:0] arith_res;
    logic [W-1:0] logic_res;
    flags_t       cand;
    flags_t       flags_q;

    // Classify the operation code.
    always_comb begin
        op       = alu_op_e'(op_i);
        is_arith = (op == OP_ADD) || (op == OP_SUB);
        is_cmp   = (op == OP_CMP);
        is_known = (op_i <= OP_SHF);
    end

    alu16_arith #(.W(W)) u_arith (
        .sub_i  (op != OP_ADD),
        .src_i  (src_i),
        .dst_i  (dst_i),
        .res_o  (arith_res),
        .cand_o (cand)
    );

    alu16_logic #(.W(W)) u_logic (
        .op_i   (op),
        .src_i  (src_i),
        .dst_i  (dst_i),
        .res_o  (logic_res)
    );

    alu16_flagreg u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_arith_i (exec_i && is_arith),
        .upd_cmp_i   (exec_i && is_cmp),
        .cand_i      (cand),
        .flags_o     (flags_q)
    );

    // Choose the result and the write-back strobe.
    always_comb begin
        result_o = (is_arith || is_cmp) ? arith_res : logic_res;
        wb_o     = exec_i && is_known && !is_cmp;
    end

    assign flags_o = flags_q;

    assert_cmp_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_CMP) |=> (flags_o[3] == $past(src_i == dst_i)));

    assert_cmp_below_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_CMP) |=> (flags_o[2] == $past(dst_i < src_i)));

    assert_lui_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LUI) |-> (result_o[W/2-1:0] == '0));

    assert_shift_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SHF) |-> (src_i[W-1] ? !result_o[W-1] : !result_o[0]));

    assert_no_exec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> $stable(flags_o));

endmodule

// File: tb/sim_alu16_flags.sv
module sim_alu16_flags;
    import alu16_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [15:0] src_i = 16'd0;
    logic [15:0] dst_i = 16'd0;
    logic [15:0] result_o;
    logic        wb_o;
    logic [4:0]  flags_o;

    int checks = 0;
    int errors = 0;
    logic [4:0] mflags = 5'd0;   // bench model of the status bits

    always #5 clk = ~clk;

    alu16_flags u0 (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
        .src_i(src_i), .dst_i(dst_i), .result_o(result_o),
        .wb_o(wb_o), .flags_o(flags_o)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation, check result/write-back now and flags after the edge.
    task automatic run(string tag, logic [3:0] op, logic [15:0] s, logic [15:0] d, logic ex);
        logic [15:0] r;
        logic [16:0] full;
        logic [4:0]  nf;
        logic        w;
        nf = mflags;
        w  = ex && (op <= 4'd8) && (op != 4'd2);
        case (op)
            4'd0: begin
                full = {1'b0, d} + {1'b0, s};
                r = full[15:0];
                if (ex) begin
                    nf[0] = full[16];
                    nf[1] = (d[15] == s[15]) && (r[15] != d[15]);
                end
            end
            4'd1, 4'd2: begin
                r = d - s;
                if (ex && op == 4'd1) begin
                    nf[0] = (d >= s);
                    nf[1] = (d[15] != s[15]) && (r[15] != d[15]);
                end
                if (ex && op == 4'd2) begin
                    nf[3] = (d == s);
                    nf[2] = (d < s);
                    nf[4] = ($signed(d) < $signed(s));
                end
            end
            4'd3: r = d & s;
            4'd4: r = d | s;
            4'd5: r = d ^ s;
            4'd6: r = s;
            4'd7: r = {s[7:0], 8'h00};
            4'd8: r = s[15] ? (d >> 1) : (d << 1);
            default: r = d;
        endcase
        exec_i = ex; op_i = op; src_i = s; dst_i = d;
        #1;
        chk({tag, " result"}, result_o, r);
        chk({tag, " wb"}, {15'd0, wb_o}, {15'd0, w});
        @(negedge clk);
        mflags = nf;
        chk({tag, " flags"}, {11'd0, flags_o}, {11'd0, mflags});
        exec_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 reset flags", {11'd0, flags_o}, 16'd0);
    endtask

    task automatic t_add;
        run("R1 R3 R13 add plain", 4'd0, 16'h0001, 16'h1234, 1'b1);
        run("R1 R3 add carry", 4'd0, 16'h0001, 16'hFFFF, 1'b1);
        run("R1 R3 add overflow", 4'd0, 16'h0001, 16'h7FFF, 1'b1);
    endtask

    task automatic t_sub;
        run("R2 R3 sub no borrow", 4'd1, 16'h0003, 16'h0005, 1'b1);
        run("R2 R3 sub borrow", 4'd1, 16'h0005, 16'h0003, 1'b1);
        run("R2 R3 sub overflow", 4'd1, 16'h0001, 16'h8000, 1'b1);
    endtask

    task automatic t_cmp;
        run("R4 cmp equal", 4'd2, 16'h1234, 16'h1234, 1'b1);
        run("R4 cmp below both", 4'd2, 16'h0002, 16'h0001, 1'b1);
        run("R4 cmp signed only", 4'd2, 16'h0001, 16'hFFFF, 1'b1);
        run("R4 cmp unsigned only", 4'd2, 16'hFFFF, 16'h0001, 1'b1);
    endtask

    task automatic t_logic;
        run("R5 R9 and", 4'd3, 16'h0FF0, 16'h3C3C, 1'b1);
        run("R5 R9 or", 4'd4, 16'h0FF0, 16'h3C3C, 1'b1);
        run("R5 R9 xor", 4'd5, 16'h0FF0, 16'h3C3C, 1'b1);
        run("R6 R9 mov", 4'd6, 16'hBEEF, 16'h0000, 1'b1);
        run("R7 R9 lui", 4'd7, 16'hFFAB, 16'h1111, 1'b1);
    endtask

    task automatic t_shift;
        run("R8 shift left", 4'd8, 16'h0001, 16'h8001, 1'b1);
        run("R8 shift right", 4'd8, 16'hFFFF, 16'h8001, 1'b1);
    endtask

    task automatic t_idle;
        run("R10 add without exec", 4'd0, 16'h0001, 16'h7FFF, 1'b0);
        run("R10 cmp without exec", 4'd2, 16'h0000, 16'h0000, 1'b0);
    endtask

    task automatic t_unused;
        run("R12 code 9", 4'd9, 16'h5555, 16'hA5A5, 1'b1);
        run("R12 code 15", 4'd15, 16'hFFFF, 16'h0001, 1'b1);
    endtask

    task automatic t_reset_mid;
        run("R3 set carry", 4'd0, 16'h0001, 16'hFFFF, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mflags = 5'd0;
        chk("R11 mid-run reset flags", {11'd0, flags_o}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_shift();
        t_idle();
        t_unused();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule